// File: doc/BRIEF.md
# Memory Access Lane Aligner

This block sits between a processor core and a 32-bit data memory. Each clock it may receive one memory instruction together with the value of its base register and, for stores, the value of the source register. It decodes the instruction's direction, sign and size bits and forms the effective address as the base plus the sign-extended 16-bit offset. It then issues one registered memory request with a lane-aligned address, byte enables and, for stores, data copied onto the selected lanes.

Accesses are byte, 16-bit word or 32-bit double. Misaligned word and double accesses are not trapped: the low address bits are cleared. For loads the block keeps the lane offset, size, sign flag and destination register index of the request. When the memory answers, it moves the addressed lane down to bit 0, zero- or sign-extends it to 32 bits and presents it with the destination index one cycle later. Only one load may be outstanding.

Top module: `mem_lane_aligner`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is 0 after that edge, whatever the other inputs are.
- R2: An instruction is a memory operation when `req_valid` is 1 and `instr[31:28]` is 0001. After that edge `mem_req` is 1. Any other opcode, or `req_valid` at 0, leaves `mem_req`, `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` all 0 after the edge.
- R3: `instr[27]` selects the direction (1 store, 0 load) and drives `mem_we`. A load request puts 0 on `mem_wdata`.
- R4: `mem_addr` is `base_addr` plus `instr[15:0]` sign-extended to 32 bits, modulo 2^32. For size 01 bit 0 is forced to 0. For sizes 10 and 11 bits 1:0 are forced to 0.
- R5: `instr[25:24]` is the size: 00 byte, 01 word (16 bits), 10 and 11 double (32 bits). `mem_be` is little-endian, with bit n enabling data bits 8n+7..8n. A byte access sets the single bit given by address bits 1:0. A word access sets 0011 when address bit 1 is 0 and 1100 when it is 1. A double access sets 1111.
- R6: Store data is the source's low byte repeated in all four lanes (byte), the low 16 bits repeated in both halves (word), or the whole source (double). `instr[26]` has no effect on a store.
- R7: A load result is the addressed byte or word of `mem_rdata`, moved down to bit 0. It is sign-extended to 32 bits when the load's `instr[26]` was 1 and zero-extended when it was 0. A double load returns `mem_rdata` unchanged.
- R8: `ld_valid` is `mem_rvalid` delayed one cycle. On a response, `ld_data` and `ld_dest` take the result and the `instr[23:20]` of the most recent load issued before that edge. Between responses both hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Instruction on `instr` is presented this cycle |
| instr | input | 32 | Instruction word |
| base_addr | input | 32 | Value of the base register |
| store_src | input | 32 | Value of the register to store |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Aligned byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rvalid | input | 1 | Read data valid from memory |
| mem_rdata | input | 32 | Read data from memory |
| ld_valid | output | 1 | Load result valid |
| ld_dest | output | 4 | Destination register index of the load |
| ld_data | output | 32 | Extracted and extended load result |

## Verification
The hardest case to reach from the ports is a load response arriving on the same edge that a new load replaces the saved load context. The result must then use the old offset, size, sign flag and destination. The bench gets there by issuing loads back to back and answering each one on the cycle after its request appears, so every response edge is also the next request edge. It also uses small bases with negative offsets, so the effective address wraps below zero and the lane is taken from the wrapped low bits.

// File: rtl/mla_pkg.sv
// Shared definitions for the memory lane aligner.
// Assumes a 32-bit instruction word and a 32-bit little-endian data path.
package mla_pkg;

    localparam int unsigned INSTR_W    = 32;
    localparam logic [3:0]  MEM_OPCODE = 4'b0001;

    // Access size field of a memory instruction
    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_FULL     = 2'b10,
        SZ_FULL_ALT = 2'b11
    } size_e;

    // Decoded control bits of a memory instruction
    typedef struct packed {
        logic       is_store;
        logic       sign_ext;
        size_e      size;
        logic [3:0] dest;
    } mem_ctl_t;

    // What a pending load needs to shape its response
    typedef struct packed {
        logic       sign_ext;
        size_e      size;
        logic [1:0] offset;
        logic [3:0] dest;
    } ld_ctx_t;

endpackage

// File: rtl/mla_decode.sv
// Decodes a memory instruction and forms the aligned address and lane enables.
// Assumes a 4-lane data path; sizes 10 and 11 both mean a full-width access.
module mla_decode
    import mla_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned LANES  = 4
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  base_addr,
    output logic               is_mem,
    output mem_ctl_t           ctl,
    output logic [1:0]         offset,
    output logic [ADDR_W-1:0]  addr_aligned,
    output logic [LANES-1:0]   be
);

    localparam int unsigned EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] addr_sum;
    logic [3:0]        unused_base_idx;

    // Field extraction from the instruction word
    assign is_mem          = (instr[31:28] == MEM_OPCODE);
    assign ctl.is_store    = instr[27];
    assign ctl.sign_ext    = instr[26];
    assign ctl.size        = size_e'(instr[25:24]);
    assign ctl.dest        = instr[23:20];
    assign unused_base_idx = instr[19:16];

    // Effective address: base plus sign-extended offset
    assign addr_sum = base_addr + {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    // Lane offset after forced alignment
    always_comb begin
        case (ctl.size)
            SZ_BYTE: offset = addr_sum[1:0];
            SZ_HALF: offset = {addr_sum[1], 1'b0};
            default: offset = 2'b00;
        endcase
    end

    assign addr_aligned = {addr_sum[ADDR_W-1:2], offset};

    // One enable per byte lane
    for (genvar i = 0; i < LANES; i++) begin : g_be
        localparam logic [1:0] LANE = 2'(i);
        assign be[i] = (ctl.size == SZ_BYTE) ? (offset == LANE) :
                       (ctl.size == SZ_HALF) ? (offset[1] == LANE[1]) :
                       1'b1;
    end

endmodule

// File: rtl/mla_store_steer.sv
// Copies store data onto every lane a narrow access could address.
// Assumes DATA_W is 32 so that a word covers two lanes.
module mla_store_steer
    import mla_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  size_e             size,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] wdata
);

    localparam int unsigned LANES = DATA_W / 8;

    // Per-lane source byte selection
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wdata[8*i +: 8] = (size == SZ_BYTE) ? src[7:0] :
                                 (size == SZ_HALF) ? src[8*(i%2) +: 8] :
                                 src[8*i +: 8];
    end

endmodule

// File: rtl/mla_load_extract.sv
// Moves the addressed lane of read data down to bit 0 and extends it.
// Assumes the offset was already aligned for the access size.
module mla_load_extract
    import mla_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] rdata,
    input  size_e             size,
    input  logic [1:0]        offset,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] value
);

    logic [DATA_W-1:0] shifted;

    // Lane shift down by the byte offset
    assign shifted = rdata >> {offset, 3'b000};

    // Zero or sign extension by size
    always_comb begin
        case (size)
            SZ_BYTE: value = {{(DATA_W-8){sign_ext & shifted[7]}}, shifted[7:0]};
            SZ_HALF: value = {{(DATA_W-16){sign_ext & shifted[15]}}, shifted[15:0]};
            default: value = rdata;
        endcase
    end

endmodule

// File: rtl/mem_lane_aligner.sv
// Top of the memory lane aligner: registers one memory request per cycle
// and shapes the read response of the single outstanding load.
// Assumes at most one load in flight and a response for it before the
// edge that would need the context of a later load.
module mem_lane_aligner
    import mla_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [INSTR_W-1:0]    instr,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [DATA_W-1:0]     store_src,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic                  mem_rvalid,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  ld_valid,
    output logic [3:0]            ld_dest,
    output logic [DATA_W-1:0]     ld_data
);

    localparam int unsigned LANES = DATA_W / 8;

    logic              is_mem;
    mem_ctl_t          ctl;
    logic [1:0]        offset;
    logic [ADDR_W-1:0] addr_aligned;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] steered;
    logic [DATA_W-1:0] extracted;
    ld_ctx_t           ctx_q;
    logic              issue;

    mla_decode #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .LANES  (LANES)
    ) i_decode (
        .instr        (instr),
        .base_addr    (base_addr),
        .is_mem       (is_mem),
        .ctl          (ctl),
        .offset       (offset),
        .addr_aligned (addr_aligned),
        .be           (be)
    );

    mla_store_steer #(
        .DATA_W (DATA_W)
    ) i_store_steer (
        .size  (ctl.size),
        .src   (store_src),
        .wdata (steered)
    );

    mla_load_extract #(
        .DATA_W (DATA_W)
    ) i_load_extract (
        .rdata    (mem_rdata),
        .size     (ctx_q.size),
        .offset   (ctx_q.offset),
        .sign_ext (ctx_q.sign_ext),
        .value    (extracted)
    );

    assign issue = req_valid && is_mem;

    // Request register toward memory, zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end else if (issue) begin
            mem_req   <= 1'b1;
            mem_we    <= ctl.is_store;
            mem_addr  <= addr_aligned;
            mem_be    <= be;
            mem_wdata <= ctl.is_store ? steered : '0;
        end else begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end
    end

    // Context of the latest load, used to shape its response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (issue && !ctl.is_store) begin
            ctx_q.sign_ext <= ctl.sign_ext;
            ctx_q.size     <= ctl.size;
            ctx_q.offset   <= offset;
            ctx_q.dest     <= ctl.dest;
        end
    end

    // Load result register, updated on each response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_dest  <= '0;
            ld_data  <= '0;
        end else begin
            ld_valid <= mem_rvalid;
            if (mem_rvalid) begin
                ld_dest <= ctx_q.dest;
                ld_data <= extracted;
            end
        end
    end

endmodule

// File: rtl/mla_checker.sv
// Property checker for the memory lane aligner, bound to the top module.
module mla_checker
    import mla_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [INSTR_W-1:0]  instr,
    input logic                mem_req,
    input logic                mem_we,
    input logic [31:0]         mem_addr,
    input logic [3:0]          mem_be,
    input logic [31:0]         mem_wdata,
    input logic                mem_rvalid,
    input logic                ld_valid
);

    // R2: a non-memory opcode never yields a request
    p_no_req_other_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && instr[31:28] != MEM_OPCODE) |-> !mem_req);

    // R3: a write is always part of a request, and loads carry no data
    p_we_inside_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
    p_load_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_wdata == '0));

    // R5: only legal lane patterns appear
    p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                     mem_be == 4'b1100 || mem_be == 4'b1111));

    // R4: address alignment agrees with the lane pattern
    p_align_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00));
    p_align_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_be == 4'b0011 || mem_be == 4'b1100)) |->
        (mem_addr[0] == 1'b0 && mem_addr[1] == mem_be[2]));

    // R6: a byte store carries the same byte on every lane
    p_byte_repl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $countones(mem_be) == 1) |->
        (mem_wdata[7:0] == mem_wdata[15:8] && mem_wdata[15:8] == mem_wdata[23:16] &&
         mem_wdata[23:16] == mem_wdata[31:24]));

    // R8: a result appears only after a response
    p_ld_after_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rvalid));

endmodule

bind mem_lane_aligner mla_checker i_mla_checker (.*);

// File: tb/test_mem_lane_aligner.sv
// Bench for the memory lane aligner: a behavioural model predicts every
// output for each clock and all outputs are compared on every falling edge.
module test_mem_lane_aligner;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_addr = '0;
    logic [31:0] store_src = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req, mem_we, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be, ld_dest;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model expectations
    logic        e_req = 0, e_we = 0, e_ldv = 0;
    logic [31:0] e_addr = 0, e_wdata = 0, e_ldd = 0;
    logic [3:0]  e_be = 0, e_ldest = 0;
    logic [9:0]  pend_q[$];

    mem_lane_aligner i_mem_lane_aligner (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .instr (instr),
        .base_addr (base_addr), .store_src (store_src),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_be (mem_be), .mem_wdata (mem_wdata),
        .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
        .ld_valid (ld_valid), .ld_dest (ld_dest), .ld_data (ld_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input logic [3:0] op, input logic st, input logic sg,
                                       input logic [1:0] sz, input logic [3:0] rd,
                                       input logic [15:0] imm);
        return {op, st, sg, sz, rd, 4'h5, imm};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        check(mem_req === e_req,     "R2 mem_req",   32'(mem_req), 32'(e_req));
        check(mem_we === e_we,       "R3 mem_we",    32'(mem_we), 32'(e_we));
        check(mem_addr === e_addr,   "R4 mem_addr",  mem_addr, e_addr);
        check(mem_be === e_be,       "R5 mem_be",    32'(mem_be), 32'(e_be));
        check(mem_wdata === e_wdata, "R6 mem_wdata", mem_wdata, e_wdata);
        check(ld_valid === e_ldv,    "R8 ld_valid",  32'(ld_valid), 32'(e_ldv));
        check(ld_dest === e_ldest,   "R8 ld_dest",   32'(ld_dest), 32'(e_ldest));
        check(ld_data === e_ldd,     "R7 ld_data",   ld_data, e_ldd);
    endtask

    // Predicts the outputs that follow the coming rising edge
    task automatic predict();
        if (!rst_n) begin
            e_req = 0; e_we = 0; e_addr = 0; e_be = 0; e_wdata = 0;
            e_ldv = 0; e_ldest = 0; e_ldd = 0;
            pend_q.delete();
            return;
        end
        if (mem_rvalid) begin
            logic [9:0] c;
            int off, sz, v;
            c   = pend_q.pop_front();
            sz  = int'(c[8:7]);
            off = int'(c[6:5]);
            e_ldv = 1; e_ldest = c[3:0];
            if (sz == 0) begin
                v = int'((mem_rdata >> (8 * off)) & 32'hFF);
                if (c[9] && v > 127) v -= 256;
                e_ldd = 32'(v);
            end else if (sz == 1) begin
                v = int'((mem_rdata >> (8 * off)) & 32'hFFFF);
                if (c[9] && v > 32767) v -= 65536;
                e_ldd = 32'(v);
            end else begin
                e_ldd = mem_rdata;
            end
        end else begin
            e_ldv = 0;
        end
        if (req_valid && instr[31:28] == 4'd1) begin
            logic [31:0] ea;
            int sz, off;
            sz  = (instr[25:24] == 2'd3) ? 2 : int'(instr[25:24]);
            ea  = base_addr + 32'($signed(instr[15:0]));
            off = (sz == 0) ? int'(ea % 4) : (sz == 1) ? int'(ea % 4) / 2 * 2 : 0;
            e_req  = 1;
            e_we   = instr[27];
            e_addr = ea - (ea % 4) + 32'(off);
            e_be   = (sz == 0) ? 4'(1 << off) : (sz == 1) ? ((off >= 2) ? 4'hC : 4'h3) : 4'hF;
            if (!instr[27]) begin
                e_wdata = 0;
                pend_q.push_back({instr[26], 2'(sz), 2'(off), 1'b0, instr[23:20]});
            end else begin
                e_wdata = (sz == 0) ? 32'(store_src[7:0]) * 32'h0101_0101 :
                          (sz == 1) ? 32'(store_src[15:0]) * 32'h0001_0001 : store_src;
            end
        end else begin
            e_req = 0; e_we = 0; e_addr = 0; e_be = 0; e_wdata = 0;
        end
    endtask

    // One clock: apply inputs, answer a pending load, predict, then compare
    task automatic cyc(input logic rn, input logic v, input logic [31:0] ins,
                       input logic [31:0] b, input logic [31:0] s);
        rst_n = rn; req_valid = v; instr = ins; base_addr = b; store_src = s;
        mem_rvalid = rn && e_req && !e_we;
        mem_rdata  = $urandom;
        predict();
        @(negedge clk);
        compare();
    endtask

    initial begin
        // R1: reset with live inputs
        for (int i = 0; i < 3; i++)
            cyc(1'b0, 1'b1, mk(4'd1, 1'b1, 1'b0, 2'd2, 4'd3, 16'h0004), 32'h100, 32'hDEAD_BEEF);
        check(mem_req === 1'b0 && ld_valid === 1'b0 && mem_wdata === '0, "R1 reset state",
              {mem_req, ld_valid, 30'(mem_wdata)}, 32'h0);

        // every size, offset, direction and sign flag
        for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 4; off++)
                for (int st = 0; st < 2; st++)
                    for (int sg = 0; sg < 2; sg++)
                        cyc(1'b1, 1'b1, mk(4'd1, 1'(st), 1'(sg), 2'(sz), 4'(sz*4+off), 16'h0010),
                            32'h0000_2000 + 32'(off), 32'h8899_AABB);

        // R2: other opcodes and an idle memory opcode have no effect
        for (int op = 0; op < 16; op++)
            if (op != 1) cyc(1'b1, 1'b1, mk(4'(op), 1'b1, 1'b0, 2'd2, 4'd1, 16'h0), 32'h40, 32'h1234_5678);
        cyc(1'b1, 1'b0, mk(4'd1, 1'b1, 1'b0, 2'd0, 4'd1, 16'h0), 32'h40, 32'h1234_5678);

        // R4: negative offsets wrapping below zero
        cyc(1'b1, 1'b1, mk(4'd1, 1'b0, 1'b1, 2'd0, 4'd7, 16'hFFFD), 32'h2, 0);
        cyc(1'b1, 1'b1, mk(4'd1, 1'b0, 1'b1, 2'd1, 4'd8, 16'hFFFF), 32'h0, 0);
        cyc(1'b1, 1'b1, mk(4'd1, 1'b1, 1'b0, 2'd3, 4'd9, 16'h8000), 32'h1, 32'hCAFE_F00D);

        // random traffic, mostly memory opcodes
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ins;
            ins = $urandom;
            if ($urandom % 8 != 0) ins[31:28] = 4'd1;
            cyc(1'b1, 1'($urandom % 5 != 0), ins,
                ($urandom % 4 == 0) ? 32'($urandom % 8) : 32'($urandom), $urandom);
        end
        cyc(1'b1, 1'b0, 0, 0, 0);
        cyc(1'b1, 1'b0, 0, 0, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule